// File: doc/BRIEF.md
# Cycle-by-Cycle Peak and Valley Current Limiter

This block is the digital gate-control stage of a synchronous step-down converter. It sits between the PWM request from the modulator and the enables of the high-side and low-side switch drivers. It takes two comparator flags from the analog current sense. One flag reports overcurrent through the high-side switch (peak). The other reports overcurrent through the low-side switch (valley). Both flags are synchronized into the clock domain. Each flag is then blanked for a programmable number of cycles after its own switch turns on, so that switching noise at turn-on is ignored.

A peak trip that survives blanking ends the high-side pulse at once. The low side then turns on through the usual dead-time gap. The high side may turn on again only on a fresh PWM period. A valley trip holds the high side off for as long as the valley flag stays set. Any PWM request that meets the hold is skipped as a whole pulse and is never started late. During soft-start, trips only limit current, and a clamp request asks the compensation loop to limit its output. Once soft-start is complete, a trip raises a single-cycle hiccup request. An external fault input forces both enables off.

The controller is a six-state machine:
- IDLE: both switches off, for one cycle after reset or after a fault. It goes to HS_ON when a pulse is granted, otherwise to LS_ON.
- HS_ON: the high side conducts. It goes to GAP_HL on a falling PWM request or on a peak trip.
- GAP_HL: both switches off for the dead time. It then goes to LS_ON.
- LS_ON: the low side conducts. It goes to GAP_LH when a pulse is granted.
- GAP_LH: both switches off for the dead time. It then goes to HS_ON.
- FAULT: both switches off. It is entered from any state while the fault input is high and goes to IDLE when the input falls.

Top module: `pulse_current_limiter`

## Requirements
- R1: During reset, hs_en, ls_en, oc_event, hiccup_req and comp_clamp are all 0.
- R2: With no trips, a rising pwm_req turns ls_en off and turns hs_en on DEAD_CYC+1 cycles later. A falling pwm_req turns hs_en off and turns ls_en on DEAD_CYC+1 cycles later. For a request held high for P cycles, hs_en is high for P-DEAD_CYC cycles.
- R3: hs_en and ls_en are never high in the same cycle, and a falling edge of either is followed by at least one cycle with both low.
- R4: The peak flag is ignored for the first BLANK_HS cycles of each high-side pulse. With the flag already set at turn-on, the pulse lasts exactly BLANK_HS+1 cycles (11 by default).
- R5: After a peak trip, ls_en turns on through the dead-time gap even though pwm_req is still high. hs_en stays low until pwm_req has gone low and risen again, and the new pulse then starts after the normal DEAD_CYC+1 cycles.
- R6: A valley flag that is set and cleared within the first BLANK_LS cycles of a low-side interval (40 by default) neither delays the next high-side pulse nor raises oc_event.
- R7: A valley trip after blanking keeps hs_en low while the synchronized valley flag stays set. A PWM request that arrives during the hold is skipped in full, even if the flag clears before the request ends. The next request after that starts normally.
- R8: oc_event is high in each cycle that follows a cycle with a qualified trip (a peak trip in HS_ON, or a valley trip in LS_ON, after blanking).
- R9: hiccup_req is a single-cycle pulse, raised once per trip episode and only while ss_done is 1. With ss_done at 0 it never rises.
- R10: comp_clamp is 1 while ss_done is 0 and either a peak cut is pending in the current period or a valley hold is active. It is 0 when ss_done is 1 and once the limiting condition has cleared.
- R11: While fault_off is high, hs_en and ls_en are both low in the same cycle. After fault_off falls, the block passes through IDLE for one cycle and then follows pwm_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_req | input | 1 | PWM request from the modulator (1 = high-side phase) |
| peak_flag | input | 1 | Asynchronous high-side overcurrent comparator flag |
| valley_flag | input | 1 | Asynchronous low-side overcurrent comparator flag |
| ss_done | input | 1 | Soft-start complete |
| fault_off | input | 1 | External fault; forces both enables off |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| oc_event | output | 1 | Qualified overcurrent seen in the previous cycle |
| hiccup_req | output | 1 | Single-cycle hiccup request |
| comp_clamp | output | 1 | Request to clamp the error-amplifier output |

## Verification
Suppose a blanking counter does not restart, or restarts one cycle late. Then the width of a peak-limited pulse differs from BLANK_HS+1 on the very first truncated pulse, and oc_event moves by the same number of cycles. Suppose the cut latch or the skip latch is lost. Then hs_en reappears within DEAD_CYC+1 cycles inside a period that should stay dark. If a latch sticks, the next clean period fails to start. A wrong dead-time count or a wrong fault path shows up directly as a changed turn-on delay, or as an enable that is still high in the cycle the fault input rises.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    typedef enum logic [2:0] {
        GS_IDLE   = 3'd0,
        GS_HS_ON  = 3'd1,
        GS_GAP_HL = 3'd2,
        GS_LS_ON  = 3'd3,
        GS_GAP_LH = 3'd4,
        GS_FAULT  = 3'd5
    } gate_state_t;

endpackage

// File: rtl/pcl_sync.sv
module pcl_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= async_i;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else begin
                    stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pcl_blank.sv
module pcl_blank #(
    parameter int BLANK = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en,
    output logic open_o
);

    localparam int CW = $clog2(BLANK + 1);

    logic [CW-1:0] cnt_q;

    // Counter is held at zero while the gate is off, so every rising
    // edge of the gate starts a fresh blanking window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!gate_en) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(BLANK)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign open_o = gate_en && (cnt_q == CW'(BLANK));

    // R4 / R6
    blank_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> !open_o);

endmodule

// File: rtl/pcl_gate_fsm.sv
module pcl_gate_fsm
    import pcl_pkg::*;
#(
    parameter int DEAD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req,
    input  logic peak_s,
    input  logic valley_s,
    input  logic peak_open,
    input  logic valley_open,
    input  logic ss_done,
    input  logic fault_off,
    output logic hs_en,
    output logic ls_en,
    output logic oc_event,
    output logic hiccup_req,
    output logic comp_clamp
);

    localparam int DW = $clog2(DEAD_CYC + 1);

    gate_state_t   state_q, state_nx;
    logic [DW-1:0] dcnt_q;
    logic          peak_cut_q;
    logic          skip_pend_q;
    logic          valley_hold_q;
    logic          peak_trip, valley_trip, grant, gap_done, in_gap;

    assign peak_trip   = (state_q == GS_HS_ON) && peak_open && peak_s;
    assign valley_trip = (state_q == GS_LS_ON) && valley_open && valley_s;
    assign grant       = pwm_req && !peak_cut_q && !skip_pend_q && !valley_hold_q;
    assign in_gap      = (state_q == GS_GAP_HL) || (state_q == GS_GAP_LH);
    assign gap_done    = (dcnt_q == DW'(DEAD_CYC - 1));

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            GS_IDLE: begin
                if (fault_off)      state_nx = GS_FAULT;
                else if (grant)     state_nx = GS_HS_ON;
                else                state_nx = GS_LS_ON;
            end
            GS_HS_ON: begin
                if (fault_off)                  state_nx = GS_FAULT;
                else if (peak_trip || !pwm_req) state_nx = GS_GAP_HL;
            end
            GS_GAP_HL: begin
                if (fault_off)      state_nx = GS_FAULT;
                else if (gap_done)  state_nx = GS_LS_ON;
            end
            GS_LS_ON: begin
                if (fault_off)      state_nx = GS_FAULT;
                else if (grant)     state_nx = GS_GAP_LH;
            end
            GS_GAP_LH: begin
                if (fault_off)      state_nx = GS_FAULT;
                else if (gap_done)  state_nx = GS_HS_ON;
            end
            GS_FAULT: begin
                if (!fault_off)     state_nx = GS_IDLE;
            end
            default:                state_nx = GS_FAULT;
        endcase
    end

    // State register and dead-time counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
            dcnt_q  <= '0;
        end else begin
            state_q <= state_nx;
            if (state_nx != state_q || !in_gap) begin
                dcnt_q <= '0;
            end else begin
                dcnt_q <= dcnt_q + 1'b1;
            end
        end
    end

    // Limit latches and registered reports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_cut_q    <= 1'b0;
            skip_pend_q   <= 1'b0;
            valley_hold_q <= 1'b0;
            oc_event      <= 1'b0;
            hiccup_req    <= 1'b0;
        end else begin
            if (!pwm_req)       peak_cut_q <= 1'b0;
            else if (peak_trip) peak_cut_q <= 1'b1;

            if (!pwm_req)                                     skip_pend_q <= 1'b0;
            else if (state_q == GS_LS_ON && valley_hold_q)    skip_pend_q <= 1'b1;

            if (valley_trip)    valley_hold_q <= 1'b1;
            else if (!valley_s) valley_hold_q <= 1'b0;

            oc_event   <= peak_trip || valley_trip;
            hiccup_req <= ss_done && (peak_trip || valley_trip) && !oc_event;
        end
    end

    // Outputs
    always_comb begin
        hs_en      = (state_q == GS_HS_ON) && !fault_off;
        ls_en      = (state_q == GS_LS_ON) && !fault_off;
        comp_clamp = !ss_done && (peak_cut_q || valley_hold_q);
    end

    // R3
    hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_en) |=> !ls_en);

    // R3
    ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ls_en) |=> !hs_en);

    // R5
    cut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (peak_cut_q && pwm_req) |-> !hs_en);

    // R7
    skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_LS_ON && valley_hold_q && !fault_off) |=> (state_q != GS_GAP_LH));

    // R9
    hiccup_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hiccup_req |=> !hiccup_req);

    // R9
    hiccup_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hiccup_req |-> $past(ss_done));

endmodule

// File: rtl/pulse_current_limiter.sv
module pulse_current_limiter #(
    parameter int BLANK_HS    = 10,
    parameter int BLANK_LS    = 40,
    parameter int DEAD_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req,
    input  logic peak_flag,
    input  logic valley_flag,
    input  logic ss_done,
    input  logic fault_off,
    output logic hs_en,
    output logic ls_en,
    output logic oc_event,
    output logic hiccup_req,
    output logic comp_clamp
);

    localparam int NFLAG = 2;

    logic [NFLAG-1:0] flag_sync;
    logic             peak_open, valley_open;

    pcl_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({valley_flag, peak_flag}),
        .sync_o  (flag_sync)
    );

    pcl_blank #(.BLANK(BLANK_HS)) u_blank_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_en (hs_en),
        .open_o  (peak_open)
    );

    pcl_blank #(.BLANK(BLANK_LS)) u_blank_ls (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_en (ls_en),
        .open_o  (valley_open)
    );

    pcl_gate_fsm #(.DEAD_CYC(DEAD_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_req     (pwm_req),
        .peak_s      (flag_sync[0]),
        .valley_s    (flag_sync[1]),
        .peak_open   (peak_open),
        .valley_open (valley_open),
        .ss_done     (ss_done),
        .fault_off   (fault_off),
        .hs_en       (hs_en),
        .ls_en       (ls_en),
        .oc_event    (oc_event),
        .hiccup_req  (hiccup_req),
        .comp_clamp  (comp_clamp)
    );

    // R3
    excl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    // R11
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fault_off) && fault_off |-> !hs_en && !ls_en);

endmodule

// File: tb/pulse_current_limiter_tb.sv
module pulse_current_limiter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BLANK_HS   = 10;
    localparam int BLANK_LS   = 40;
    localparam int DEAD_CYC   = 2;

    logic clk = 1'b0;
    logic rst_n, pwm_req, peak_flag, valley_flag, ss_done, fault_off;
    logic hs_en, ls_en, oc_event, hiccup_req, comp_clamp;

    int checks = 0;
    int fails  = 0;
    int excl_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_current_limiter #(
        .BLANK_HS(BLANK_HS), .BLANK_LS(BLANK_LS), .DEAD_CYC(DEAD_CYC), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .peak_flag(peak_flag),
        .valley_flag(valley_flag), .ss_done(ss_done), .fault_off(fault_off),
        .hs_en(hs_en), .ls_en(ls_en), .oc_event(oc_event),
        .hiccup_req(hiccup_req), .comp_clamp(comp_clamp)
    );

    always @(negedge clk) begin
        if (rst_n && hs_en && ls_en) excl_bad++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic until_hs(output int n);
        n = 0;
        for (int i = 1; i <= 200; i++) begin
            @(negedge clk);
            n = i;
            if (hs_en) break;
        end
    endtask

    task automatic until_ls(output int n);
        n = 0;
        for (int i = 1; i <= 200; i++) begin
            @(negedge clk);
            n = i;
            if (ls_en) break;
        end
    endtask

    task automatic t_reset();
        chk(!hs_en && !ls_en, "R1 enables in reset", {hs_en, ls_en}, 0);
        chk(!oc_event && !hiccup_req && !comp_clamp, "R1 reports in reset",
            {oc_event, hiccup_req, comp_clamp}, 0);
    endtask

    task automatic t_follow();
        int n;
        int hi;
        pwm_req = 1'b1;
        until_hs(n);
        chk(n == DEAD_CYC + 1, "R2 rise to hs_en delay", n, DEAD_CYC + 1);
        idle_cycles(20);
        pwm_req = 1'b0;
        until_ls(n);
        chk(n == DEAD_CYC + 1, "R2 fall to ls_en delay", n, DEAD_CYC + 1);
        idle_cycles(10);
        hi = 0;
        pwm_req = 1'b1;
        for (int i = 1; i <= 22; i++) begin
            @(negedge clk);
            if (hs_en) hi++;
            if (i == 12) pwm_req = 1'b0;
        end
        chk(hi == 12 - DEAD_CYC, "R2 hs_en width for 12-cycle request", hi, 12 - DEAD_CYC);
        idle_cycles(10);
    endtask

    task automatic t_peak(input bit ssd);
        int hi;
        int hic;
        int n;
        ss_done = ssd;
        peak_flag = 1'b1;
        idle_cycles(5);
        hi = 0;
        hic = 0;
        pwm_req = 1'b1;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (hs_en) hi++;
            if (hiccup_req) hic++;
            if (i == BLANK_HS + DEAD_CYC + 2) begin
                chk(!hs_en && oc_event, "R8 oc_event after peak trip", oc_event, 1);
                chk(comp_clamp == !ssd, "R10 clamp on peak cut", comp_clamp, !ssd);
                if (ssd) chk(hiccup_req, "R9 hiccup on peak trip", hiccup_req, 1);
            end
            if (i == 25) chk(ls_en, "R5 low side forced on after cut", ls_en, 1);
        end
        chk(hi == BLANK_HS + 1, "R4 peak-limited pulse width", hi, BLANK_HS + 1);
        chk(hic == (ssd ? 1 : 0), "R9 hiccup pulse count", hic, ssd ? 1 : 0);
        peak_flag = 1'b0;
        pwm_req = 1'b0;
        idle_cycles(10);
        chk(!comp_clamp, "R10 clamp cleared", comp_clamp, 0);
        pwm_req = 1'b1;
        until_hs(n);
        chk(n == DEAD_CYC + 1, "R5 next period starts", n, DEAD_CYC + 1);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (hs_en) hi++;
        end
        chk(hi == 20, "R5 full pulse after flag cleared", hi, 20);
        pwm_req = 1'b0;
        ss_done = 1'b0;
        idle_cycles(60);
    endtask

    task automatic t_valley_blank();
        int first;
        int oc_any;
        pwm_req = 1'b1;
        idle_cycles(20);
        pwm_req = 1'b0;
        valley_flag = 1'b1;
        first = 0;
        oc_any = 0;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (oc_event) oc_any++;
            if (hs_en && first == 0) first = i;
            if (i == 20) valley_flag = 1'b0;
            if (i == 35) pwm_req = 1'b1;
        end
        chk(first == 35 + DEAD_CYC + 1, "R6 blanked valley flag ignored", first, 35 + DEAD_CYC + 1);
        chk(oc_any == 0, "R6 no oc_event for blanked flag", oc_any, 0);
        pwm_req = 1'b0;
        idle_cycles(60);
    endtask

    task automatic t_valley_skip();
        int hi;
        int hic;
        int n;
        valley_flag = 1'b1;
        idle_cycles(3);
        chk(oc_event, "R8 oc_event after valley trip", oc_event, 1);
        chk(comp_clamp, "R10 clamp during valley hold", comp_clamp, 1);
        hi = 0;
        hic = 0;
        for (int p = 0; p < 2; p++) begin
            pwm_req = 1'b1;
            for (int i = 0; i < 15; i++) begin
                @(negedge clk);
                if (hs_en) hi++;
                if (hiccup_req) hic++;
            end
            pwm_req = 1'b0;
            for (int i = 0; i < 15; i++) begin
                @(negedge clk);
                if (hs_en) hi++;
                if (hiccup_req) hic++;
            end
        end
        chk(hi == 0, "R7 pulses skipped during hold", hi, 0);
        chk(hic == 0, "R9 no hiccup in soft-start", hic, 0);
        pwm_req = 1'b1;
        idle_cycles(5);
        valley_flag = 1'b0;
        hi = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (hs_en) hi++;
        end
        chk(hi == 0, "R7 request skipped as whole pulse", hi, 0);
        chk(!comp_clamp, "R10 clamp released after hold", comp_clamp, 0);
        pwm_req = 1'b0;
        idle_cycles(5);
        pwm_req = 1'b1;
        until_hs(n);
        chk(n == DEAD_CYC + 1, "R7 next request starts", n, DEAD_CYC + 1);
        pwm_req = 1'b0;
        idle_cycles(60);
    endtask

    task automatic t_valley_hiccup();
        int hic;
        ss_done = 1'b1;
        valley_flag = 1'b1;
        hic = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (hiccup_req) hic++;
        end
        chk(hic == 1, "R9 one hiccup per valley episode", hic, 1);
        chk(!comp_clamp, "R10 no clamp after soft-start", comp_clamp, 0);
        valley_flag = 1'b0;
        ss_done = 1'b0;
        idle_cycles(10);
    endtask

    task automatic t_fault();
        int n;
        pwm_req = 1'b1;
        idle_cycles(10);
        fault_off = 1'b1;
        #1;
        chk(!hs_en && !ls_en, "R11 enables drop with fault", {hs_en, ls_en}, 0);
        idle_cycles(5);
        chk(!hs_en && !ls_en, "R11 enables held off in fault", {hs_en, ls_en}, 0);
        fault_off = 1'b0;
        until_hs(n);
        chk(n == 2, "R11 resume after fault", n, 2);
        pwm_req = 1'b0;
        idle_cycles(10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        pwm_req = 1'b0;
        peak_flag = 1'b0;
        valley_flag = 1'b0;
        ss_done = 1'b0;
        fault_off = 1'b0;
        idle_cycles(5);
        t_reset();
        rst_n = 1'b1;
        idle_cycles(60);
        t_follow();
        t_peak(1'b0);
        t_peak(1'b1);
        t_valley_blank();
        t_valley_skip();
        t_valley_hiccup();
        t_fault();
        chk(excl_bad == 0, "R3 enables never overlap", excl_bad, 0);
        summary();
        $finish;
    end

endmodule